// File: doc/BRIEF.md
# ISA Bus Cycle Timer

This block paces expansion-bus cycles from a fast system clock. It divides the system clock by a programmable integer to make a one-cycle bus-clock enable. It then runs each accepted CPU request through four phases: an optional setup delay, a command strobe whose length depends on the transfer width, a recovery interval, and a return to idle. All phase lengths are counted in bus-clock periods.

The CPU raises `req` with the width and memory/I/O flags and holds it until `rdy` pulses. The attributes are captured when the request is accepted. A request that arrives while the previous cycle is still in recovery waits until recovery has finished. The timing inputs are expected to stay stable while `busy` is high.

After every cycle there is a fixed minimum gap of `MIN_GAP` bus periods. When recovery insertion is enabled, I/O cycles add a width-specific recovery count on top of that gap. Address decoding and data steering are handled elsewhere.

Top module: `isa_cycle_timer`

## Requirements
- R1: `bclk_en` is high for exactly one system clock in every N system clocks, where N is `div_sel`; any `div_sel` value below 2 is treated as 2.
- R2: `cmd` rises or falls only at a clock edge where `bclk_en` was high in the cycle before that edge.
- R3: `cmd` stays high for (1 + `wait8`) bus periods on an 8-bit cycle (`req_w16`=0) and for (1 + `wait16`) bus periods on a 16-bit cycle (`req_w16`=1), so it is high for that count times N system clocks. It sees exactly that many `bclk_en` pulses while high.
- R4: After a request is accepted, `cmd` rises at the edge that follows the (`setup_cnt` + 1)-th `bclk_en` pulse seen while busy. A `setup_cnt` of 0 gives no extra delay.
- R5: For an I/O cycle (`req_io`=1) with `rcv_en`=1, `busy` stays high for (`MIN_GAP` + R) × N system clocks after `cmd` falls. R is `rcv8` for an 8-bit cycle and `rcv16` for a 16-bit cycle.
- R6: For a memory cycle (`req_io`=0), or for any cycle when `rcv_en`=0, the interval after `cmd` falls is only `MIN_GAP` × N system clocks.
- R7: `rdy` is a single-cycle pulse. It is high in the second system clock after `cmd` falls, exactly once per command.
- R8: A request that is held high during recovery does not start a new command. It is accepted only after `busy` has been low for one clock, and its timing then follows R3 to R6.
- R9: After reset `cmd`, `rdy` and `busy` are low. `busy` is high from the clock after a request is accepted until recovery ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | DIV_W | Bus clock divider N (values below 2 act as 2) |
| wait8 | input | CNT_W | Extra command periods for 8-bit cycles |
| wait16 | input | CNT_W | Extra command periods for 16-bit cycles |
| rcv8 | input | CNT_W | Recovery periods added after 8-bit I/O cycles |
| rcv16 | input | CNT_W | Recovery periods added after 16-bit I/O cycles |
| rcv_en | input | 1 | Enables recovery insertion for I/O cycles |
| setup_cnt | input | CNT_W | Bus periods of delay before the command |
| req | input | 1 | CPU cycle request, held until `rdy` |
| req_w16 | input | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bclk_en | output | 1 | One-cycle bus clock enable |
| cmd | output | 1 | Bus command strobe, active high |
| rdy | output | 1 | Cycle-complete pulse to the CPU |
| busy | output | 1 | A cycle is in setup, command or recovery |

## Verification
On every clock, the assertions check the following:
- the enable is a single-cycle pulse;
- the strobe changes only on bus-clock ticks;
- the phase counters hold between ticks;
- `rdy` follows each falling strobe as one isolated pulse inside the busy window.

Some properties can only be shown by the bench's scenarios, which measure whole cycles:
- the exact strobe and recovery lengths for each width, each cycle type and each enable setting;
- the number of setup ticks;
- the divider clamp;
- the hold-off of a request raised during recovery.

// File: rtl/isa_tmg_pkg.sv
package isa_tmg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CMD   = 2'd2,
    ST_RECOV = 2'd3
  } cyc_st_e;

  typedef struct packed {
    logic w16;
    logic io;
  } cyc_attr_t;
endpackage

// File: rtl/isa_clk_div.sv
module isa_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             bclk_en
);
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    div_eff = (div_sel < DIV_W'(2)) ? DIV_W'(2) : div_sel;
    last    = (cnt_q >= (div_eff - DIV_W'(1)));
    cnt_d   = last ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bclk_en = last;

  // R1
  bclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |=> !bclk_en);
endmodule

// File: rtl/isa_cnt_sel.sv
module isa_cnt_sel
  import isa_tmg_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int GAP_W   = 5,
  parameter int MIN_GAP = 1
) (
  input  cyc_attr_t        attr,
  input  logic [CNT_W-1:0] wait8,
  input  logic [CNT_W-1:0] wait16,
  input  logic [CNT_W-1:0] rcv8,
  input  logic [CNT_W-1:0] rcv16,
  input  logic             rcv_en,
  output logic [GAP_W-1:0] wait_ld,
  output logic [GAP_W-1:0] gap_ld
);
  logic [CNT_W-1:0] rcv_pick;
  logic [GAP_W-1:0] gap_total;

  always_comb begin
    wait_ld   = GAP_W'(attr.w16 ? wait16 : wait8);
    rcv_pick  = attr.w16 ? rcv16 : rcv8;
    gap_total = GAP_W'(MIN_GAP);
    if (attr.io && rcv_en) gap_total = gap_total + GAP_W'(rcv_pick);
    gap_ld    = gap_total - GAP_W'(1);
  end
endmodule

// File: rtl/isa_cyc_fsm.sv
module isa_cyc_fsm
  import isa_tmg_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int GAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_en,
  input  logic             req,
  input  logic             req_w16,
  input  logic             req_io,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [GAP_W-1:0] wait_ld,
  input  logic [GAP_W-1:0] gap_ld,
  output cyc_attr_t        attr,
  output logic             cmd,
  output logic             rdy,
  output logic             busy
);
  cyc_st_e          st_q, st_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  cyc_attr_t        attr_q, attr_d;
  logic             cmd_d1_q, rdy_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    attr_d = attr_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d       = ST_SETUP;
          cnt_d      = GAP_W'(setup_cnt);
          attr_d.w16 = req_w16;
          attr_d.io  = req_io;
        end
      end
      ST_SETUP: begin
        if (bclk_en) begin
          if (cnt_zero) begin
            st_d  = ST_CMD;
            cnt_d = wait_ld;
          end else begin
            cnt_d = cnt_q - GAP_W'(1);
          end
        end
      end
      ST_CMD: begin
        if (bclk_en) begin
          if (cnt_zero) begin
            st_d  = ST_RECOV;
            cnt_d = gap_ld;
          end else begin
            cnt_d = cnt_q - GAP_W'(1);
          end
        end
      end
      ST_RECOV: begin
        if (bclk_en) begin
          if (cnt_zero) st_d  = ST_IDLE;
          else          cnt_d = cnt_q - GAP_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      attr_q   <= '0;
      cmd_d1_q <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      attr_q   <= attr_d;
      cmd_d1_q <= cmd;
      rdy_q    <= cmd_d1_q & ~cmd;
    end
  end

  assign cmd  = (st_q == ST_CMD);
  assign busy = (st_q != ST_IDLE);
  assign rdy  = rdy_q;
  assign attr = attr_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bclk_en) |=> $stable(cnt_q));

  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
endmodule

// File: rtl/isa_cycle_timer.sv
module isa_cycle_timer
  import isa_tmg_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int CNT_W   = 4,
  parameter int MIN_GAP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [CNT_W-1:0] wait8,
  input  logic [CNT_W-1:0] wait16,
  input  logic [CNT_W-1:0] rcv8,
  input  logic [CNT_W-1:0] rcv16,
  input  logic             rcv_en,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic             req,
  input  logic             req_w16,
  input  logic             req_io,
  output logic             bclk_en,
  output logic             cmd,
  output logic             rdy,
  output logic             busy
);
  localparam int GAP_W = $clog2(MIN_GAP + (1 << CNT_W)) + 1;

  logic             rst_s1_q, rst_s2_q;
  cyc_attr_t        attr;
  logic [GAP_W-1:0] wait_ld, gap_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  isa_clk_div #(.DIV_W(DIV_W)) div_i (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .div_sel (div_sel),
    .bclk_en (bclk_en)
  );

  isa_cnt_sel #(.CNT_W(CNT_W), .GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) sel_i (
    .attr    (attr),
    .wait8   (wait8),
    .wait16  (wait16),
    .rcv8    (rcv8),
    .rcv16   (rcv16),
    .rcv_en  (rcv_en),
    .wait_ld (wait_ld),
    .gap_ld  (gap_ld)
  );

  isa_cyc_fsm #(.CNT_W(CNT_W), .GAP_W(GAP_W)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .bclk_en   (bclk_en),
    .req       (req),
    .req_w16   (req_w16),
    .req_io    (req_io),
    .setup_cnt (setup_cnt),
    .wait_ld   (wait_ld),
    .gap_ld    (gap_ld),
    .attr      (attr),
    .cmd       (cmd),
    .rdy       (rdy),
    .busy      (busy)
  );

  // R2
  cmd_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $rose(cmd) |-> $past(bclk_en));

  // R2
  cmd_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $fell(cmd) |-> $past(bclk_en));

  // R7
  rdy_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $fell(cmd) |=> rdy);

  // R9
  rdy_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    rdy |-> busy);
endmodule

// File: tb/isa_cycle_timer_tb_top.sv
module isa_cycle_timer_tb_top;
  localparam int MIN_GAP = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_sel = 4'd3;
  logic [3:0] wait8 = 4'd2, wait16 = 4'd1, rcv8 = 4'd5, rcv16 = 4'd3;
  logic       rcv_en = 1'b1;
  logic [3:0] setup_cnt = 4'd0;
  logic       req = 1'b0, req_w16 = 1'b0, req_io = 1'b0;
  logic       bclk_en, cmd, rdy, busy;

  int total = 0;
  int bad   = 0;

  typedef struct {
    int    setup_t;
    int    cmd_c;
    int    cmd_t;
    int    gap_c;
    string gtag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  isa_cycle_timer dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .wait8(wait8), .wait16(wait16),
    .rcv8(rcv8), .rcv16(rcv16), .rcv_en(rcv_en), .setup_cnt(setup_cnt),
    .req(req), .req_w16(req_w16), .req_io(req_io),
    .bclk_en(bclk_en), .cmd(cmd), .rdy(rdy), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int div_eff();
    return (div_sel < 2) ? 2 : int'(div_sel);
  endfunction

  task automatic do_cycle(input logic w16, input logic io, input string gtag);
    exp_t e;
    int n;
    n = div_eff();
    e.setup_t = int'(setup_cnt) + 1;
    e.cmd_t   = (w16 ? int'(wait16) : int'(wait8)) + 1;
    e.cmd_c   = e.cmd_t * n;
    e.gap_c   = (MIN_GAP + ((io && rcv_en) ? (w16 ? int'(rcv16) : int'(rcv8)) : 0)) * n;
    e.gtag    = gtag;
    exp_q.push_back(e);
    @(negedge clk);
    req = 1'b1; req_w16 = w16; req_io = io;
    do @(negedge clk); while (!rdy);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || exp_q.size() != 0);
    @(negedge clk);
  endtask

  task automatic check_period(input int expv);
    int n;
    repeat (2) begin
      do @(negedge clk); while (!bclk_en);
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!bclk_en);
    check("R1 bus clock period", n, expv);
  endtask

  // monitor / scoreboard
  logic pb = 0, pc = 0, pc2 = 0, pe = 0, seen_cmd = 0;
  int   s_t = 0, c_c = 0, c_t = 0, g_c = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!pb && busy) begin
        seen_cmd = 0; s_t = 0; c_c = 0; c_t = 0; g_c = 0;
      end
      if (busy && !cmd && !seen_cmd && bclk_en) s_t++;
      if (cmd) begin
        seen_cmd = 1; c_c++;
        if (bclk_en) c_t++;
      end
      if (busy && !cmd && seen_cmd) g_c++;
      if (cmd && !pc) check("R2 cmd rise after tick", int'(pe), 1);
      if (rdy || (pc2 && !pc && !cmd)) check("R7 rdy two clocks after cmd fall", int'(rdy), int'(pc2 && !pc));
      if (pb && !busy) begin
        if (exp_q.size() == 0) check("R8 unexpected cycle", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R4 setup ticks", s_t, e.setup_t);
          check("R3 cmd system clocks", c_c, e.cmd_c);
          check("R3 cmd bus ticks", c_t, e.cmd_t);
          check({e.gtag, " recovery clocks"}, g_c, e.gap_c);
        end
      end
      pc2 = pc; pc = cmd; pb = busy; pe = bclk_en;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 cmd after reset", int'(cmd), 0);
    check("R9 rdy after reset", int'(rdy), 0);
    check("R9 busy after reset", int'(busy), 0);

    check_period(3);
    do_cycle(1'b0, 1'b1, "R5");
    wait_idle();
    do_cycle(1'b1, 1'b1, "R5");
    wait_idle();
    do_cycle(1'b0, 1'b0, "R6");
    wait_idle();
    rcv_en = 1'b0;
    do_cycle(1'b0, 1'b1, "R6");
    wait_idle();
    rcv_en = 1'b1; setup_cnt = 4'd2;
    do_cycle(1'b1, 1'b1, "R5");
    wait_idle();
    setup_cnt = 4'd0;
    // R8: second request raised while the first is in recovery
    do_cycle(1'b0, 1'b1, "R8");
    check("R8 busy when next request raised", int'(busy), 1);
    do_cycle(1'b0, 1'b1, "R8");
    wait_idle();
    div_sel = 4'd0; wait16 = 4'd0;
    check_period(2);
    do_cycle(1'b1, 1'b0, "R6");
    wait_idle();
    div_sel = 4'd6; wait8 = 4'd0; rcv8 = 4'd1;
    check_period(6);
    do_cycle(1'b0, 1'b1, "R5");
    wait_idle();
    check("R8 queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule